// File: doc/BRIEF.md
# Two-Bank Level-Sensitive Interrupt Router

This block collects up to 64 level-sensitive interrupt lines (40 by default) and steers each one to one of two request outputs: a fast request and a normal request. The lines are held in 32-bit banks. Sources 0 to 31 live in the first bank and sources 32 and up occupy the low bits of the second bank. Each bank has an enable mask and a routing word. A routing bit of 1 sends its source to the fast output and a 0 sends it to the normal output. The pending state is the live input level. Nothing latches it, so a source drops out as soon as its line falls.

A third output requests wake-up while the processor core reports it is idle. An idle-control bit chooses the wake rule. Either only enabled sources may wake the core, or any pending source may wake it whatever the mask says. The three request outputs come from flops and change one clock after the state that feeds them.

Software reaches the block through a single-cycle register port. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address. The port gives read and write access to the mask, routing and idle-control words. It gives read-only access to three pending views: the lines routed to the normal output, the lines routed to the fast output, and the raw lines.

Top module: `irq_router`

## Requirements
- R1: After reset both banks' mask and routing words read 0, the idle-control word at byte offset 0x14 reads 1, and `fiq_o`, `irq_o` and `wake_o` are low.
- R2: The raw pending view reads the current input levels with no latching, in the same cycle as the input. Bank 1 at offset 0x10 gives sources 0..31. Bank 2 at offset 0xAC gives sources 32..39 in bits 7:0, with bits 31:8 zero.
- R3: `fiq_o` is high one clock after any source is high, enabled and routed with a routing bit of 1, in either bank, and low one clock after no such source exists.
- R4: `irq_o` behaves the same way for sources that are high, enabled and routed with a routing bit of 0.
- R5: The normal-pending view (0x00 bank 1, 0x9C bank 2) reads pending AND mask AND NOT routing. The fast-pending view (0x0C bank 1, 0xA8 bank 2) reads pending AND mask AND routing.
- R6: The mask words (0x04 bank 1, 0xA0 bank 2) and the routing words (0x08 bank 1, 0xA4 bank 2) are written and read back whole. Bank 2 bits 31:8, which have no source behind them, always read 0.
- R7: A write to offset 0x14 stores bit 0 of the write data as the idle-control bit, and a read of 0x14 returns that bit in bit 0 with all other bits zero.
- R8: `wake_o` is high one clock after `core_idle_i` is high and at least one pending source is enabled, or pending with the idle-control bit at 0. Otherwise it is low one clock later.
- R9: Reads of unmapped offsets return 0. This includes offset 0x18, which is kept free for a priority encoder. Writes to unmapped or read-only offsets change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt line levels, high means pending |
| core_idle_i | input | 1 | Core is halted and waiting for a wake request |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Register byte offset for reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| fiq_o | output | 1 | Fast interrupt request, registered |
| irq_o | output | 1 | Normal interrupt request, registered |
| wake_o | output | 1 | Wake request while idle, registered |

## Verification
Read data is combinational, so each register read is sampled a short delay after the address is driven on a falling edge, before the next rising edge. The raw pending view is also read just after a line changes, which shows it is not latched. A write is driven on a falling edge and is stored at the next rising edge. The fast, normal and wake outputs then need one further rising edge after both the line change and the register update. The bench therefore samples them at the falling edge that follows that edge. It also takes one sample just before that edge, to show that the outputs have not yet moved.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int BANK_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] IDLE_OFF = 8'h14;

  typedef enum logic [2:0] {
    V_IRQP,
    V_MASK,
    V_ROUTE,
    V_FIQP,
    V_RAW,
    V_NONE
  } view_e;

  // Base offset of each bank's window of five words.
  function automatic logic [ADDR_W-1:0] bank_base(input int bank);
    if (bank == 0) return 8'h00;
    return 8'h9C;
  endfunction

  // Which word of a bank an address selects, if any.
  function automatic view_e decode_view(input logic [ADDR_W-1:0] addr, input int bank);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    base = bank_base(bank);
    off  = addr - base;
    if (addr < base) return V_NONE;
    case (off)
      8'h00:   return V_IRQP;
      8'h04:   return V_MASK;
      8'h08:   return V_ROUTE;
      8'h0C:   return V_FIQP;
      8'h10:   return V_RAW;
      default: return V_NONE;
    endcase
  endfunction

  // Bits of a bank that have a source behind them.
  function automatic logic [BANK_W-1:0] valid_bits(input int nsrc, input int bank);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = ((bank * BANK_W + i) < nsrc);
    return m;
  endfunction

  // Pending lines steered to one output: fast_sel=1 keeps routing bits of 1.
  function automatic logic [BANK_W-1:0] route_filter(input logic [BANK_W-1:0] pend,
                                                     input logic [BANK_W-1:0] mask,
                                                     input logic [BANK_W-1:0] route,
                                                     input logic              fast_sel);
    return pend & mask & (fast_sel ? route : ~route);
  endfunction

  // Pending lines allowed to wake the idle core.
  function automatic logic [BANK_W-1:0] wake_filter(input logic [BANK_W-1:0] pend,
                                                    input logic [BANK_W-1:0] mask,
                                                    input logic              any_src);
    return pend & (mask | {BANK_W{any_src}});
  endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_router_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int NUM_SRC  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] pend_i,
  input  logic              any_wake_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] route_o,
  output logic              fast_req_o,
  output logic              norm_req_o,
  output logic              wake_req_o,
  output logic [BANK_W-1:0] rd_data_o
);

  localparam logic [BANK_W-1:0] VALID = valid_bits(NUM_SRC, BANK_IDX);

  view_e             sel_view;
  logic [BANK_W-1:0] mask_q;
  logic [BANK_W-1:0] route_q;
  logic [BANK_W-1:0] pend_v;
  logic [BANK_W-1:0] fast_bits;
  logic [BANK_W-1:0] norm_bits;
  logic [BANK_W-1:0] wake_bits;

  assign sel_view = decode_view(addr_i, BANK_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en_i) begin
      if (sel_view == V_MASK)  mask_q  <= wdata_i & VALID;
      if (sel_view == V_ROUTE) route_q <= wdata_i & VALID;
    end
  end

  assign pend_v    = pend_i & VALID;
  assign fast_bits = route_filter(pend_v, mask_q, route_q, 1'b1);
  assign norm_bits = route_filter(pend_v, mask_q, route_q, 1'b0);
  assign wake_bits = wake_filter(pend_v, mask_q, any_wake_i);

  assign fast_req_o = |fast_bits;
  assign norm_req_o = |norm_bits;
  assign wake_req_o = |wake_bits;
  assign mask_o     = mask_q;
  assign route_o    = route_q;

  always_comb begin
    case (sel_view)
      V_IRQP:  rd_data_o = norm_bits;
      V_MASK:  rd_data_o = mask_q;
      V_ROUTE: rd_data_o = route_q;
      V_FIQP:  rd_data_o = fast_bits;
      V_RAW:   rd_data_o = pend_v;
      default: rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_rd_merge.sv
module irq_rd_merge
  import irq_router_pkg::*;
#(
  parameter int NBANK = 2
) (
  input  logic [NBANK-1:0][BANK_W-1:0] bank_data_i,
  input  logic [BANK_W-1:0]            ctrl_data_i,
  output logic [BANK_W-1:0]            rdata_o
);

  // Each source returns zero when not addressed, so an OR merges them.
  always_comb begin
    rdata_o = ctrl_data_i;
    for (int b = 0; b < NBANK; b++) rdata_o = rdata_o | bank_data_i[b];
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] fast_req_i,
  input  logic [NBANK-1:0] norm_req_i,
  input  logic [NBANK-1:0] wake_req_i,
  input  logic             core_idle_i,
  output logic             fiq_o,
  output logic             irq_o,
  output logic             wake_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_o  <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      fiq_o  <= |fast_req_i;
      irq_o  <= |norm_req_i;
      wake_o <= core_idle_i & (|wake_req_i);
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               core_idle_i,
  input  logic               wr_en_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               fiq_o,
  output logic               irq_o,
  output logic               wake_o
);

  localparam int NBANK = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int PAD_W = NBANK * BANK_W;

  // Named internal events for the checker.
  logic [PAD_W-1:0]               pend_pad;
  logic [PAD_W-1:0]               mask_all;
  logic [PAD_W-1:0]               route_all;
  logic [NBANK-1:0]               fast_b;
  logic [NBANK-1:0]               norm_b;
  logic [NBANK-1:0]               wake_b;
  logic [NBANK-1:0][BANK_W-1:0]   bank_rd;
  logic                           idle_only_q;
  logic [BANK_W-1:0]              ctrl_rd;

  always_comb begin
    pend_pad              = '0;
    pend_pad[NUM_SRC-1:0] = src_i;
  end

  // Idle-control bit: 1 means only enabled sources may wake the core.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              idle_only_q <= 1'b1;
    else if (wr_en_i && addr_i == IDLE_OFF)  idle_only_q <= wdata_i[0];
  end

  assign ctrl_rd = (addr_i == IDLE_OFF) ? {{(BANK_W-1){1'b0}}, idle_only_q} : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_bank #(
      .BANK_IDX (b),
      .NUM_SRC  (NUM_SRC)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_pad[b*BANK_W +: BANK_W]),
      .any_wake_i (~idle_only_q),
      .wr_en_i    (wr_en_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .mask_o     (mask_all[b*BANK_W +: BANK_W]),
      .route_o    (route_all[b*BANK_W +: BANK_W]),
      .fast_req_o (fast_b[b]),
      .norm_req_o (norm_b[b]),
      .wake_req_o (wake_b[b]),
      .rd_data_o  (bank_rd[b])
    );
  end

  irq_rd_merge #(.NBANK(NBANK)) u_merge (
    .bank_data_i (bank_rd),
    .ctrl_data_i (ctrl_rd),
    .rdata_o     (rdata_o)
  );

  irq_out_stage #(.NBANK(NBANK)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_req_i  (fast_b),
    .norm_req_i  (norm_b),
    .wake_req_i  (wake_b),
    .core_idle_i (core_idle_i),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 40
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   core_idle_i,
  input logic [7:0]                             addr_i,
  input logic [31:0]                            rdata_o,
  input logic                                   fiq_o,
  input logic                                   irq_o,
  input logic                                   wake_o,
  input logic [((NUM_SRC+31)/32)*32-1:0]        pend_all,
  input logic [((NUM_SRC+31)/32)*32-1:0]        mask_all,
  input logic [((NUM_SRC+31)/32)*32-1:0]        route_all,
  input logic                                   idle_only
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r3_fiq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (fiq_o == $past(|(pend_all & mask_all & route_all))));

  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_o == $past(|(pend_all & mask_all & ~route_all))));

  a_r8_wake_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(core_idle_i)) |-> !wake_o);

  a_r8_wake_rule: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (wake_o == $past(core_idle_i &&
                               (|(pend_all & (mask_all | {$bits(mask_all){~idle_only}}))))));

  a_r2_raw_view: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 8'h10) |-> (rdata_o == pend_all[31:0]));

  a_r5_fast_view: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 8'h0C) |-> (rdata_o == (pend_all[31:0] & mask_all[31:0] & route_all[31:0])));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 8'h18) |-> (rdata_o == 32'h0));

endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_idle_i (core_idle_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .fiq_o       (fiq_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o),
  .pend_all    (pend_pad),
  .mask_all    (mask_all),
  .route_all   (route_all),
  .idle_only   (idle_only_q)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;

  localparam int NSRC = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            core_idle = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      addr = 8'h40;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            fiq, irq, wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  irq_router #(.NUM_SRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .core_idle_i(core_idle),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h40;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #2;
    chk(req, rdata, exp);
    addr = 8'h40;
  endtask

  task automatic set_regs(input logic [63:0] m, input logic [63:0] r);
    wr(8'h04, m[31:0]);
    wr(8'hA0, m[63:32]);
    wr(8'h08, r[31:0]);
    wr(8'hA4, r[63:32]);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] m64, r64, s64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 mask1", 8'h04, 32'h0);
    rd_chk("R1 mask2", 8'hA0, 32'h0);
    rd_chk("R1 route1", 8'h08, 32'h0);
    rd_chk("R1 route2", 8'hA4, 32'h0);
    rd_chk("R1 idle", 8'h14, 32'h1);
    chk("R1 outputs", {29'h0, fiq, irq, wake}, 32'h0);

    // R3 R4 R5: sweep every source alone under every mask/routing pair
    for (int s = 0; s < NSRC; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic m, r;
        logic [31:0] bit_w;
        m = c[1]; r = c[0];
        m64 = m ? (64'd1 << s) : 64'd0;
        r64 = r ? (64'd1 << s) : 64'd0;
        set_regs(m64, r64);
        src = '0;
        src[s] = 1'b1;
        @(negedge clk);
        chk("R3 fiq sweep", {31'h0, fiq}, {31'h0, m & r});
        chk("R4 irq sweep", {31'h0, irq}, {31'h0, m & ~r});
        bit_w = 32'd1 << (s % 32);
        rd_chk("R5 norm view", (s < 32) ? 8'h00 : 8'h9C, (m && !r) ? bit_w : 32'h0);
        rd_chk("R5 fast view", (s < 32) ? 8'h0C : 8'hA8, (m && r) ? bit_w : 32'h0);
      end
    end

    // R3 timing: output holds before the edge, moves after it
    set_regs(64'h1, 64'h1);
    src = '0;
    @(negedge clk);
    src[0] = 1'b1;
    #2;
    chk("R3 before edge", {31'h0, fiq}, 32'h0);
    @(negedge clk);
    chk("R3 after edge", {31'h0, fiq}, 32'h1);
    src[0] = 1'b0;
    @(negedge clk);
    chk("R3 level drop", {31'h0, fiq}, 32'h0);

    // R6 mixed pattern, bank 2 upper bits dropped
    m64 = 64'hFFFF_FF33_5555_5555;
    r64 = 64'h0000_00F0_0F0F_0F0F;
    set_regs(m64, r64);
    src = '1;
    @(negedge clk);
    rd_chk("R6 mask1", 8'h04, 32'h5555_5555);
    rd_chk("R6 mask2", 8'hA0, 32'h0000_0033);
    rd_chk("R6 route1", 8'h08, 32'h0F0F_0F0F);
    rd_chk("R6 route2", 8'hA4, 32'h0000_00F0);
    rd_chk("R5 norm1 mix", 8'h00, 32'h5555_5555 & ~32'h0F0F_0F0F);
    rd_chk("R5 fast1 mix", 8'h0C, 32'h5555_5555 & 32'h0F0F_0F0F);
    rd_chk("R5 norm2 mix", 8'h9C, 32'h33 & ~32'hF0);
    rd_chk("R5 fast2 mix", 8'hA8, 32'h33 & 32'hF0);
    chk("R3 fiq mix", {31'h0, fiq}, 32'h1);
    chk("R4 irq mix", {31'h0, irq}, 32'h1);

    // R9 writes to read-only and unmapped offsets leave stored words alone
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h9C, 32'hFFFF_FFFF);
    wr(8'hA8, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h0E, 32'hFFFF_FFFF);
    rd_chk("R9 mask1 kept", 8'h04, 32'h5555_5555);
    rd_chk("R9 route1 kept", 8'h08, 32'h0F0F_0F0F);
    rd_chk("R9 mask2 kept", 8'hA0, 32'h0000_0033);
    rd_chk("R9 route2 kept", 8'hA4, 32'h0000_00F0);
    rd_chk("R9 idle kept", 8'h14, 32'h1);
    rd_chk("R9 prio slot zero", 8'h18, 32'h0);
    rd_chk("R9 unmapped 40", 8'h40, 32'h0);
    rd_chk("R9 unmapped B0", 8'hB0, 32'h0);
    rd_chk("R9 unmapped 06", 8'h06, 32'h0);

    // R2 raw view follows the lines in the same cycle
    s64 = 64'h0000_00A5_1234_5678;
    src = s64[NSRC-1:0];
    rd_chk("R2 raw1", 8'h10, 32'h1234_5678);
    rd_chk("R2 raw2", 8'hAC, 32'h0000_00A5);
    src = '0;
    rd_chk("R2 raw1 cleared", 8'h10, 32'h0);
    rd_chk("R2 raw2 cleared", 8'hAC, 32'h0);

    // R7 R8 idle control and wake
    set_regs(64'h0, 64'h0);
    src = '0;
    src[5] = 1'b1;
    core_idle = 1'b1;
    wr(8'h14, 32'hFFFF_FFFE);
    rd_chk("R7 idle any", 8'h14, 32'h0);
    @(negedge clk);
    chk("R8 wake any source", {31'h0, wake}, 32'h1);
    chk("R3 no fiq unmasked", {31'h0, fiq}, 32'h0);
    wr(8'h14, 32'h1);
    rd_chk("R7 idle enabled only", 8'h14, 32'h1);
    @(negedge clk);
    chk("R8 wake masked off", {31'h0, wake}, 32'h0);
    wr(8'h04, 32'h20);
    @(negedge clk);
    chk("R8 wake enabled", {31'h0, wake}, 32'h1);
    core_idle = 1'b0;
    @(negedge clk);
    chk("R8 wake not idle", {31'h0, wake}, 32'h0);
    core_idle = 1'b1;
    src = '0;
    src[36] = 1'b1;
    wr(8'h14, 32'h0);
    @(negedge clk);
    chk("R8 wake bank2 any", {31'h0, wake}, 32'h1);
    src = '0;
    @(negedge clk);
    chk("R8 wake none pending", {31'h0, wake}, 32'h0);
    core_idle = 1'b0;

    done = 1;
    summary();
    $finish;
  end

endmodule